// File: doc/BRIEF.md
# Three-Pulse RR Rhythm Classifier

The block watches a single-bit heartbeat marker that goes high once for each detected R wave, together with a sample tick (nominally one per millisecond). It times the gap between successive markers by counting ticks. Each new marker completes a sliding group of three beats. The middle beat of that group is judged on the two gaps around it: it can be an irregular beat (the first gap is too short compared with the whole span), a fast beat (either gap is short), a slow beat (either gap is long), or any mix of these.

Four running tallies are kept: all beats, irregular beats, fast beats and slow beats. Each tally is available as a binary value and as two decimal digits coded for active-low seven-segment displays. An end-of-data strobe drops the timing lock, so that a new record starts measuring from its own first beat while the tallies carry on.

Top module: `rr_triplet_classifier`

## Requirements
- R1: While rst_n is low and right after it rises, all four tallies read 0 and every digit output shows the pattern for 0.
- R2: A beat is a rising edge of `beat` (high in a cycle after a low one). Each beat raises `qrs_count` by one, however long `beat` stays high. The tallies change on the clock edge that sees the rise.
- R3: A gap is the number of cycles with `tick` high from the earlier beat up to the cycle before the later beat. A tick in the same cycle as a beat counts toward the gap that follows. A gap stops growing at 65535.
- R4: The first and second beats after reset or end-of-data only lock timing and raise `qrs_count`. Classification starts at the third beat and then happens on every beat, using the last two gaps.
- R5: With d12 the older gap, d23 the newer gap and d13 = d12 + d23, the middle beat is irregular when 10·d12 < 4·d13. Equality is not irregular.
- R6: The middle beat is fast when d12 < 429 or d23 < 429.
- R7: The middle beat is slow when d12 > 1500 or d23 > 1500.
- R8: The three judgements are made on their own, so one beat can raise several tallies in the same cycle.
- R9: Every tally stops at 99 and never wraps.
- R10: A cycle with `stream_done` high clears the gap timer and the beat group. A beat rising in that cycle is dropped, so no tally changes. The tallies keep their values.
- R11: Each tally drives a tens digit (`*_seg_hi`) and a ones digit (`*_seg_lo`). The bits are ordered g (bit 6) down to a (bit 0), and a 0 bit lights a segment. The digits 0 to 9 give 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample tick, one gap unit per high cycle |
| beat | input | 1 | R-wave marker; a rising edge is one beat |
| stream_done | input | 1 | End-of-data strobe; drops the timing lock |
| qrs_count | output | 8 | Tally of all beats |
| arr_count | output | 8 | Tally of irregular beats |
| tachy_count | output | 8 | Tally of fast beats |
| brady_count | output | 8 | Tally of slow beats |
| qrs_seg_hi | output | 7 | Tens digit of the beat tally |
| qrs_seg_lo | output | 7 | Ones digit of the beat tally |
| arr_seg_hi | output | 7 | Tens digit of the irregular tally |
| arr_seg_lo | output | 7 | Ones digit of the irregular tally |
| tachy_seg_hi | output | 7 | Tens digit of the fast tally |
| tachy_seg_lo | output | 7 | Ones digit of the fast tally |
| brady_seg_hi | output | 7 | Tens digit of the slow tally |
| brady_seg_lo | output | 7 | Ones digit of the slow tally |

## Verification
End-of-data and a beat edge can land in the same cycle. The bench provokes this while the beat group is full, by raising `beat` and `stream_done` together. It then judges two things: the beat tally must stay the same, and the next two beats must only relock without raising a classification tally. A tick that coincides with a beat is the other overlap. Gaps of exactly 428 and 429 ticks, with the tick running every cycle, show which gap that tick was charged to.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;

  localparam int CAT_QRS   = 0;
  localparam int CAT_ARR   = 1;
  localparam int CAT_TACHY = 2;
  localparam int CAT_BRADY = 3;
  localparam int NUM_CAT   = 4;

  typedef enum logic [1:0] {FILL_NONE, FILL_ONE, FILL_TWO} win_fill_e;

  // part/whole below num/den, cross-multiplied so no divider is needed
  function automatic logic ratio_short(input longint unsigned part,
                                       input longint unsigned whole,
                                       input longint unsigned num,
                                       input longint unsigned den);
    return (part * den) < (whole * num);
  endfunction

  function automatic logic [3:0] dec_tens(input int unsigned v);
    return 4'((v / 10) % 10);
  endfunction

  function automatic logic [3:0] dec_ones(input int unsigned v);
    return 4'(v % 10);
  endfunction

  // active-high segments, bit 6 = g ... bit 0 = a
  function automatic logic [6:0] seg_lit(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b1000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rr_interval_timer.sv
`timescale 1ns/1ps
module rr_interval_timer #(
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             pulse,
  output logic [IVL_W-1:0] ticks
);
  localparam logic [IVL_W-1:0] IVL_MAX = {IVL_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks <= '0;
    end else if (clear) begin
      ticks <= '0;
    end else if (pulse) begin
      ticks <= tick ? IVL_W'(1) : '0;
    end else if (tick && ticks != IVL_MAX) begin
      ticks <= ticks + IVL_W'(1);
    end
  end
endmodule

// File: rtl/rr_triplet_window.sv
`timescale 1ns/1ps
module rr_triplet_window import rr_pkg::*; #(
  parameter int unsigned IVL_W       = 16,
  parameter int unsigned TACHY_BELOW = 429,
  parameter int unsigned BRADY_ABOVE = 1500,
  parameter int unsigned RATIO_NUM   = 4,
  parameter int unsigned RATIO_DEN   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pulse,
  input  logic [IVL_W-1:0] ivl,
  output logic             classify,
  output logic             is_arr,
  output logic             is_tachy,
  output logic             is_brady
);
  localparam int unsigned SPAN_W = IVL_W + 1;

  win_fill_e          fill;
  logic [IVL_W-1:0]   d_prev;
  logic [SPAN_W-1:0]  span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill   <= FILL_NONE;
      d_prev <= '0;
    end else if (clear) begin
      fill   <= FILL_NONE;
      d_prev <= '0;
    end else if (pulse) begin
      case (fill)
        FILL_NONE: fill <= FILL_ONE;
        FILL_ONE: begin
          fill   <= FILL_TWO;
          d_prev <= ivl;
        end
        default: d_prev <= ivl;
      endcase
    end
  end

  assign span     = SPAN_W'(d_prev) + SPAN_W'(ivl);
  assign classify = pulse && (fill == FILL_TWO);
  assign is_arr   = ratio_short(64'(d_prev), 64'(span), 64'(RATIO_NUM), 64'(RATIO_DEN));
  assign is_tachy = (32'(d_prev) < TACHY_BELOW) || (32'(ivl) < TACHY_BELOW);
  assign is_brady = (32'(d_prev) > BRADY_ABOVE) || (32'(ivl) > BRADY_ABOVE);
endmodule

// File: rtl/rr_beat_tally.sv
`timescale 1ns/1ps
module rr_beat_tally #(
  parameter int unsigned W   = 8,
  parameter int unsigned CAP = 99
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CAP_V = W'(CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && count < CAP_V) begin
      count <= count + W'(1);
    end
  end
endmodule

// File: rtl/rr_seg_pair.sv
`timescale 1ns/1ps
module rr_seg_pair import rr_pkg::*; #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] value,
  output logic [6:0]   seg_hi,
  output logic [6:0]   seg_lo
);
  assign seg_hi = ~seg_lit(dec_tens(32'(value)));
  assign seg_lo = ~seg_lit(dec_ones(32'(value)));
endmodule

// File: rtl/rr_triplet_classifier.sv
`timescale 1ns/1ps
module rr_triplet_classifier import rr_pkg::*; #(
  parameter int unsigned IVL_W       = 16,
  parameter int unsigned TALLY_W     = 8,
  parameter int unsigned TALLY_CAP   = 99,
  parameter int unsigned TACHY_BELOW = 429,
  parameter int unsigned BRADY_ABOVE = 1500,
  parameter int unsigned RATIO_NUM   = 4,
  parameter int unsigned RATIO_DEN   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               beat,
  input  logic               stream_done,
  output logic [TALLY_W-1:0] qrs_count,
  output logic [TALLY_W-1:0] arr_count,
  output logic [TALLY_W-1:0] tachy_count,
  output logic [TALLY_W-1:0] brady_count,
  output logic [6:0]         qrs_seg_hi,
  output logic [6:0]         qrs_seg_lo,
  output logic [6:0]         arr_seg_hi,
  output logic [6:0]         arr_seg_lo,
  output logic [6:0]         tachy_seg_hi,
  output logic [6:0]         tachy_seg_lo,
  output logic [6:0]         brady_seg_hi,
  output logic [6:0]         brady_seg_lo
);
  logic              beat_q;
  logic              pulse_evt;
  logic              classify_evt;
  logic              flag_arr, flag_tachy, flag_brady;
  logic [IVL_W-1:0]  ivl_ticks;

  logic [NUM_CAT-1:0] cat_inc;
  logic [TALLY_W-1:0] cat_val [NUM_CAT];
  logic [6:0]         cat_hi  [NUM_CAT];
  logic [6:0]         cat_lo  [NUM_CAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= 1'b0;
    else        beat_q <= beat;
  end

  assign pulse_evt = beat && !beat_q && !stream_done;

  rr_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clear (stream_done),
    .pulse (pulse_evt),
    .ticks (ivl_ticks)
  );

  rr_triplet_window #(
    .IVL_W       (IVL_W),
    .TACHY_BELOW (TACHY_BELOW),
    .BRADY_ABOVE (BRADY_ABOVE),
    .RATIO_NUM   (RATIO_NUM),
    .RATIO_DEN   (RATIO_DEN)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (stream_done),
    .pulse    (pulse_evt),
    .ivl      (ivl_ticks),
    .classify (classify_evt),
    .is_arr   (flag_arr),
    .is_tachy (flag_tachy),
    .is_brady (flag_brady)
  );

  assign cat_inc[CAT_QRS]   = pulse_evt;
  assign cat_inc[CAT_ARR]   = classify_evt && flag_arr;
  assign cat_inc[CAT_TACHY] = classify_evt && flag_tachy;
  assign cat_inc[CAT_BRADY] = classify_evt && flag_brady;

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
    rr_beat_tally #(.W(TALLY_W), .CAP(TALLY_CAP)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cat_inc[g]),
      .count (cat_val[g])
    );
    rr_seg_pair #(.W(TALLY_W)) u_seg (
      .value  (cat_val[g]),
      .seg_hi (cat_hi[g]),
      .seg_lo (cat_lo[g])
    );
  end

  assign qrs_count    = cat_val[CAT_QRS];
  assign arr_count    = cat_val[CAT_ARR];
  assign tachy_count  = cat_val[CAT_TACHY];
  assign brady_count  = cat_val[CAT_BRADY];
  assign qrs_seg_hi   = cat_hi[CAT_QRS];
  assign qrs_seg_lo   = cat_lo[CAT_QRS];
  assign arr_seg_hi   = cat_hi[CAT_ARR];
  assign arr_seg_lo   = cat_lo[CAT_ARR];
  assign tachy_seg_hi = cat_hi[CAT_TACHY];
  assign tachy_seg_lo = cat_lo[CAT_TACHY];
  assign brady_seg_hi = cat_hi[CAT_BRADY];
  assign brady_seg_lo = cat_lo[CAT_BRADY];
endmodule

// File: rtl/rr_triplet_checker.sv
`timescale 1ns/1ps
module rr_triplet_checker #(
  parameter int unsigned IVL_W     = 16,
  parameter int unsigned TALLY_W   = 8,
  parameter int unsigned TALLY_CAP = 99
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stream_done,
  input logic               pulse_evt,
  input logic               classify_evt,
  input logic [IVL_W-1:0]   ivl_ticks,
  input logic [TALLY_W-1:0] qrs_count,
  input logic [TALLY_W-1:0] arr_count,
  input logic [TALLY_W-1:0] tachy_count,
  input logic [TALLY_W-1:0] brady_count
);
  localparam logic [TALLY_W-1:0] CAP_V   = TALLY_W'(TALLY_CAP);
  localparam logic [IVL_W-1:0]   IVL_TOP = {IVL_W{1'b1}};

  AST_TALLY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    qrs_count <= CAP_V && arr_count <= CAP_V && tachy_count <= CAP_V && brady_count <= CAP_V); // R9

  AST_QRS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt && qrs_count < CAP_V |=> qrs_count == $past(qrs_count) + TALLY_W'(1)); // R2

  AST_QRS_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    qrs_count != $past(qrs_count) |-> $past(pulse_evt)); // R2

  AST_CLASS_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    classify_evt |-> pulse_evt); // R4

  AST_ARR_FROM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_count != $past(arr_count) |-> $past(classify_evt)); // R5

  AST_TACHY_FROM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    tachy_count != $past(tachy_count) |-> $past(classify_evt)); // R6

  AST_BRADY_FROM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    brady_count != $past(brady_count) |-> $past(classify_evt)); // R7

  AST_IVL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_ticks == IVL_TOP && !pulse_evt && !stream_done |=> ivl_ticks == IVL_TOP); // R3

  AST_DONE_KEEPS_QRS: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> qrs_count == $past(qrs_count)); // R10

  AST_DONE_CLEARS_IVL: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> ivl_ticks == '0); // R10
endmodule

bind rr_triplet_classifier rr_triplet_checker #(
  .IVL_W     (IVL_W),
  .TALLY_W   (TALLY_W),
  .TALLY_CAP (TALLY_CAP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stream_done  (stream_done),
  .pulse_evt    (pulse_evt),
  .classify_evt (classify_evt),
  .ivl_ticks    (ivl_ticks),
  .qrs_count    (qrs_count),
  .arr_count    (arr_count),
  .tachy_count  (tachy_count),
  .brady_count  (brady_count)
);

// File: tb/test_rr_triplet_classifier.sv
`timescale 1ns/1ps
module test_rr_triplet_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic beat = 1'b0;
  logic stream_done = 1'b0;
  logic half_rate = 1'b0;

  logic [7:0] qrs_count, arr_count, tachy_count, brady_count;
  logic [6:0] qrs_seg_hi, qrs_seg_lo, arr_seg_hi, arr_seg_lo;
  logic [6:0] tachy_seg_hi, tachy_seg_lo, brady_seg_hi, brady_seg_lo;

  int checks = 0;
  int errors = 0;
  int e_qrs = 0, e_arr = 0, e_ta = 0, e_br = 0;

  // gap before each beat, then irregular / fast / slow increments of that beat
  localparam int NV = 14;
  localparam int VEC [0:NV-1][0:3] = '{
    '{5,    0, 0, 0},
    '{800,  0, 0, 0},
    '{800,  0, 0, 0},
    '{300,  0, 1, 0},
    '{900,  1, 1, 0},
    '{1600, 1, 0, 1},
    '{1000, 0, 0, 1},
    '{1500, 0, 0, 0},
    '{1501, 0, 0, 1},
    '{429,  0, 0, 1},
    '{428,  0, 1, 0},
    '{642,  0, 1, 0},
    '{963,  0, 0, 0},
    '{1445, 1, 0, 0}
  };

  rr_triplet_classifier i_rr_triplet_classifier (
    .clk, .rst_n, .tick, .beat, .stream_done,
    .qrs_count, .arr_count, .tachy_count, .brady_count,
    .qrs_seg_hi, .qrs_seg_lo, .arr_seg_hi, .arr_seg_lo,
    .tachy_seg_hi, .tachy_seg_lo, .brady_seg_hi, .brady_seg_lo
  );

  always #10 clk = ~clk;

  always @(negedge clk) tick <= half_rate ? ~tick : 1'b1;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic logic [6:0] dark_digit(input int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      default: return 7'b0010000;
    endcase
  endfunction

  task automatic check_seg(input string tag, input logic [6:0] hi, input logic [6:0] lo, input int val);
    check({tag, " tens"}, int'(hi), int'(dark_digit(val / 10)));
    check({tag, " ones"}, int'(lo), int'(dark_digit(val % 10)));
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 qrs"}, int'(qrs_count), e_qrs);
    check({tag, " R5 arr"}, int'(arr_count), e_arr);
    check({tag, " R6 tachy"}, int'(tachy_count), e_ta);
    check({tag, " R7 brady"}, int'(brady_count), e_br);
  endtask

  // rising edge of beat lands n posedges after the previous one
  task automatic beat_after(input int n);
    repeat (n - 1) @(negedge clk);
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");
    check_seg("R1/R11 qrs", qrs_seg_hi, qrs_seg_lo, 0);
    check_seg("R1/R11 brady", brady_seg_hi, brady_seg_lo, 0);

    // table walk, tick every cycle so gap equals beat spacing
    for (int r = 0; r < NV; r++) begin
      beat_after(VEC[r][0]);
      e_qrs++;
      e_arr += VEC[r][1];
      e_ta  += VEC[r][2];
      e_br  += VEC[r][3];
      check_all($sformatf("row %0d R3/R8", r));
      if (r < 2) check("R4 no judgement before third beat", int'(arr_count) + int'(tachy_count) + int'(brady_count), 0);
    end
    check_seg("R11 qrs", qrs_seg_hi, qrs_seg_lo, 14);
    check_seg("R11 arr", arr_seg_hi, arr_seg_lo, 3);
    check_seg("R11 brady", brady_seg_hi, brady_seg_lo, 4);

    // end-of-data together with a beat edge while the group is full
    @(negedge clk);
    beat = 1'b1;
    stream_done = 1'b1;
    @(negedge clk);
    beat = 1'b0;
    stream_done = 1'b0;
    check_all("R10 beat dropped with end-of-data");

    // half-rate ticks: 800-cycle spacing gives 400-tick gaps (fast)
    half_rate = 1'b1;
    beat_after(50);
    e_qrs++;
    check_all("R10 relock first");
    beat_after(800);
    e_qrs++;
    check_all("R10/R4 relock second");
    beat_after(800);
    e_qrs++;
    e_ta++;
    check_all("R3 half-rate tick gap");
    half_rate = 1'b0;

    // end-of-data alone, then a long-held beat counts once
    @(negedge clk);
    stream_done = 1'b1;
    @(negedge clk);
    stream_done = 1'b0;
    @(negedge clk);
    beat = 1'b1;
    repeat (50) @(negedge clk);
    beat = 1'b0;
    e_qrs++;
    check_all("R2 held beat");

    // gap beyond 65535 must saturate; a wrapped gap would look irregular
    beat_after(70000);
    e_qrs++;
    check_all("R3 long gap lock");
    beat_after(7000);
    e_qrs++;
    e_br++;
    check_all("R3 saturated gap");

    // many close beats drive tallies into the cap
    for (int k = 0; k < 100; k++) beat_after(2);
    e_br++;
    e_qrs = 99;
    e_ta = 99;
    check_all("R9 cap");
    check_seg("R9/R11 qrs", qrs_seg_hi, qrs_seg_lo, 99);
    check_seg("R9/R11 tachy", tachy_seg_hi, tachy_seg_lo, 99);

    // reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    e_qrs = 0; e_arr = 0; e_ta = 0; e_br = 0;
    check_all("R1 re-reset");
    check_seg("R1/R11 tachy", tachy_seg_hi, tachy_seg_lo, 0);

    summary();
    $finish;
  end
endmodule